// File: doc/BRIEF.md
# Serial Transceiver with Two-Way Clear-to-Send Flow Control

This block is a byte-wide asynchronous serial transceiver. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Flow control uses one active-high clear-to-send line in each direction. The incoming line (`cts_in`) comes from the peer. It passes through a two-stage synchronizer and then gates every new transmission. The outgoing line (`cts_out`) tells the peer to pause. It falls once the local receive queue gets close to full, so the peer has time to stop before the queue overflows.

Software reaches the block through a simple chip-select, write-enable and address port. Writes take effect at the clock edge. Reads return `rdata` combinationally in the same cycle. Bytes flow internally as streams. The transmitter takes a byte only when its valid and ready are both high in the same cycle, and its ready is low for the whole frame. The receiver presents each byte for exactly one cycle. The queue has no way to stall the receiver, so a byte offered while the queue reports not-ready (full) is discarded and flagged.

The bit period is a divider value in clock cycles and must be at least 4. The queue depth must be a power of two.

Top module: `uart_cts_core`

## Requirements
- R1: After reset, `txd` is 1 and `cts_out` is 1. The transmit-ready status (address 2, bit 0) reads 0 until `cts_in` has been high for two clock edges.
- R2: Writing address 1 while transmit-ready is 1 sends that byte. The start bit appears on `txd` after the write edge. Each bit lasts exactly the divider value (address 0) in clock cycles. Bits go out LSB first and end with one high stop bit.
- R3: A write to address 1 while transmit-ready is 0 is ignored, and no frame is produced for it.
- R4: While the synchronized `cts_in` is 0, no new start bit is issued. A frame already in progress when `cts_in` falls runs to its stop bit.
- R5: Transmit-ready equals the transmitter-idle flag ANDed with the synchronized `cts_in`.
- R6: Each correctly framed byte received on `rxd` enters the receive queue. Reading address 5 returns the oldest byte in bits 7:0 and removes it.
- R7: The receive count (address 4) rises by one on each stored byte and falls by one on each removal. A store and a removal in the same cycle leave it unchanged. Address 3 bit 0 reads 1 whenever the count is non-zero.
- R8: `cts_out` is registered. It is 0 one edge after the count is at or above 486 (of 512), and 1 one edge after the count is below 486.
- R9: A byte that arrives while the queue holds 512 bytes is discarded and sets a sticky overrun flag (address 3 bit 1). Writing address 3 with bit 1 set clears the flag.
- R10: Reading address 5 while the queue is empty returns 0 and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| cts_in | input | 1 | Peer clear-to-send, 1 = local side may transmit |
| cts_out | output | 1 | Local clear-to-send, 1 = peer may transmit |
| cs | input | 1 | Register access select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the access cycle |

## Verification
The hardest situation to reach from the ports is the queue-full corner. To get there, 512 bytes must arrive serially while nothing is read, the count must cross the 486-entry threshold on the way, and one more byte must then be dropped.

The bench gets there by playing the part of a peer that ignores `cts_out`. It streams bytes on `rxd` at a four-cycle bit period and checks `cts_out` on either side of the threshold. It then removes one byte to watch the line recover, refills the queue to full, sends the byte that must be dropped, and drains the whole queue against the scoreboard.

// File: rtl/uart_cts_pkg.sv
package uart_cts_pkg;
  typedef enum logic [2:0] {
    REG_DIV    = 3'd0,
    REG_TXDATA = 3'd1,
    REG_TXSTAT = 3'd2,
    REG_RXSTAT = 3'd3,
    REG_RXCNT  = 3'd4,
    REG_RXDATA = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             in_vld,
  output logic             in_rdy,
  input  logic [7:0]       in_data,
  output logic             txd
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             busy;
  logic [9:0]       sh;
  logic [3:0]       nbit;
  logic [DIV_W-1:0] tick;

  assign in_rdy = !busy;
  assign txd    = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      nbit <= '0;
      tick <= '0;
    end else if (!busy) begin
      if (in_vld) begin
        busy <= 1'b1;
        sh   <= {1'b1, in_data, 1'b0};
        nbit <= '0;
        tick <= '0;
      end
    end else if (tick == div - ONE) begin
      tick <= '0;
      sh   <= {1'b1, sh[9:1]};
      if (nbit == 4'd9) busy <= 1'b0;
      else              nbit <= nbit + 4'd1;
    end else begin
      tick <= tick + ONE;
    end
  end

  // R2: an accepted byte starts its frame with a low start bit
  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_rdy) |=> (txd == 1'b0 && !in_rdy));
endmodule

// File: rtl/uart_cts_rx.sv
module uart_cts_rx
  import uart_cts_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic             out_vld,
  output logic [7:0]       out_data
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             rs;
  rx_state_e        st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       nbit;
  logic [7:0]       sh;

  uart_cts_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rs)
  );

  assign out_data = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      cnt     <= '0;
      nbit    <= '0;
      sh      <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          cnt <= '0;
          if (!rs) st <= RX_START;
        end
        RX_START: begin
          if (cnt == (div >> 1) - ONE) begin
            cnt  <= '0;
            nbit <= '0;
            st   <= rs ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        RX_DATA: begin
          if (cnt == div - ONE) begin
            cnt <= '0;
            sh  <= {rs, sh[7:1]};
            if (nbit == 3'd7) st <= RX_STOP;
            else              nbit <= nbit + 3'd1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        RX_STOP: begin
          if (cnt == div - ONE) begin
            cnt     <= '0;
            st      <= RX_IDLE;
            out_vld <= rs;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // R6: each received byte is offered for exactly one cycle
  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
endmodule

// File: rtl/uart_cts_rxq.sv
module uart_cts_rxq #(
  parameter int DEPTH = 512,
  parameter int HOLD  = 486,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_vld,
  output logic             push_rdy,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             cts_q
);
  localparam int               AW      = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HOLD_C  = CNT_W'(HOLD);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty    = (count == '0);
  assign push_rdy = (count != FULL_C);
  assign do_push  = push_vld && push_rdy;
  assign do_pop   = pop && !empty;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      cts_q <= 1'b1;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + ONE_C;
        2'b01:   count <= count - ONE_C;
        default: count <= count;
      endcase
      cts_q <= (count < HOLD_C);
    end
  end

  // R7: count moves by exactly one per lone push or pop, not at all for both
  assert_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> (count == $past(count) + ONE_C));
  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count == $past(count) - ONE_C));
  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop == do_push) |=> $stable(count));
  // R9: the queue never holds more than its depth
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);
  // R8: outgoing clear-to-send follows the threshold one edge later
  assert_cts_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= HOLD_C) |=> !cts_q);
  assert_cts_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count < HOLD_C) |=> cts_q);
endmodule

// File: rtl/uart_cts_core.sv
module uart_cts_core
  import uart_cts_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter int          BUS_W     = 16,
  parameter int          DEPTH     = 512,
  parameter int          HOLD      = 486,
  parameter logic [15:0] DIV_RESET = 16'd16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  output logic             txd,
  input  logic             cts_in,
  output logic             cts_out,
  input  logic             cs,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DIV_W-1:0] div_q;
  logic             cts_ok, tx_rdy, tx_ok, tx_launch;
  logic             rx_vld, q_rdy, q_empty, q_pop, ovr;
  logic [7:0]       rx_byte, q_head;
  logic [CNT_W-1:0] q_cnt;
  logic             wr, rd;

  assign wr        = cs && we;
  assign rd        = cs && !we;
  assign tx_ok     = tx_rdy && cts_ok;
  assign tx_launch = wr && (addr == REG_TXDATA) && tx_ok;
  assign q_pop     = rd && (addr == REG_RXDATA);

  uart_cts_sync #(.STAGES(2), .RST_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_in), .q(cts_ok)
  );

  uart_cts_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q),
    .in_vld(tx_launch), .in_rdy(tx_rdy), .in_data(wdata[7:0]), .txd(txd)
  );

  uart_cts_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div_q), .rxd(rxd),
    .out_vld(rx_vld), .out_data(rx_byte)
  );

  uart_cts_rxq #(.DEPTH(DEPTH), .HOLD(HOLD), .CNT_W(CNT_W)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_vld(rx_vld), .push_rdy(q_rdy), .push_data(rx_byte),
    .pop(q_pop), .head(q_head), .count(q_cnt), .empty(q_empty),
    .cts_q(cts_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(DIV_RESET);
      ovr   <= 1'b0;
    end else begin
      if (wr && addr == REG_DIV) div_q <= wdata[DIV_W-1:0];
      if (rx_vld && !q_rdy)                          ovr <= 1'b1;
      else if (wr && addr == REG_RXSTAT && wdata[1]) ovr <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        REG_DIV:    rdata[DIV_W-1:0] = div_q;
        REG_TXSTAT: rdata[0]         = tx_ok;
        REG_RXSTAT: rdata[1:0]       = {ovr, !q_empty};
        REG_RXCNT:  rdata[CNT_W-1:0] = q_cnt;
        REG_RXDATA: rdata[7:0]       = q_empty ? 8'h00 : q_head;
        default:    rdata            = '0;
      endcase
    end
  end

  // R4: with the peer blocking, an idle transmitter stays idle
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts_ok && tx_rdy) |=> tx_rdy);
  // R9: a byte refused by a full queue raises the overrun flag
  assert_ovr_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !q_rdy) |=> ovr);
  // R1: peer permission stays low for the cycle after reset release
  assert_cts_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cts_ok) |-> $past(cts_in));
endmodule

// File: tb/uart_cts_core_tb.sv
module uart_cts_core_tb;
  localparam int CLK_NS = 20;
  localparam int DIV    = 4;
  localparam int BIT_NS = DIV * CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic        txd;
  logic        cts_in = 1'b0;
  logic        cts_out;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0;
  int fails = 0;
  int tx_frames = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #(CLK_NS/2) clk = ~clk;

  uart_cts_core u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .cts_in(cts_in),
    .cts_out(cts_out), .cs(cs), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0;
  endtask

  // driver: a byte sent on rxd; stored ones go to the scoreboard
  task automatic send_rx(input logic [7:0] b, input bit stored);
    @(negedge clk);
    if (stored) rxq.push_back(b);
    rxd = 1'b0; #(BIT_NS);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; #(BIT_NS); end
    rxd = 1'b1; #(BIT_NS);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_rx_expect();
    logic [15:0] v;
    logic [7:0]  e;
    bus_read(3'd5, v);
    e = rxq.pop_front();
    check(v == {8'h00, e}, "R6 rx byte order", v, e);
  endtask

  // monitor: decodes frames on txd and compares them with the scoreboard
  initial begin : tx_monitor
    logic [7:0] got;
    logic       stp;
    @(posedge rst_n);
    forever begin
      @(negedge txd);
      #(BIT_NS/2);
      for (int i = 0; i < 8; i++) begin #(BIT_NS); got[i] = txd; end
      #(BIT_NS); stp = txd;
      tx_frames++;
      if (txq.size() == 0) check(1'b0, "R3 R4 unexpected frame", got, 0);
      else begin
        logic [7:0] e;
        e = txq.pop_front();
        check(got == e && stp, "R2 tx frame", {stp, got}, {1'b1, e});
      end
    end
  end

  initial begin : watchdog
    #(150000 * CLK_NS);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    int frames_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R1 txd idle", txd, 1);
    check(cts_out == 1'b1, "R1 cts_out after reset", cts_out, 1);
    bus_read(3'd2, v);
    check(v == 16'd0, "R1 tx status blocked", v, 0);

    bus_write(3'd0, 16'(DIV));
    @(negedge clk);
    cts_in = 1'b1;
    @(negedge clk);
    cs = 1'b1; addr = 3'd2; #1;
    check(rdata == 16'd0, "R1 one edge not enough", rdata, 0);
    @(negedge clk); #1;
    check(rdata == 16'd1, "R1 R5 ready after two edges", rdata, 1);
    cs = 1'b0;

    // R2: frame then R3 ignored write while busy
    txq.push_back(8'hA5);
    bus_write(3'd1, 16'h00A5);
    check(txd == 1'b0, "R2 start bit after write", txd, 0);
    bus_read(3'd2, v);
    check(v == 16'd0, "R5 busy not ready", v, 0);
    bus_write(3'd1, 16'h0011);
    #(BIT_NS * 11);
    check(tx_frames == 1, "R3 one frame only", tx_frames, 1);
    txq.push_back(8'h3C);
    bus_write(3'd1, 16'h003C);
    #(BIT_NS * 11);
    check(tx_frames == 2 && txq.size() == 0, "R2 second frame", tx_frames, 2);

    // R4: cts falls mid-frame, frame completes, then new write ignored
    txq.push_back(8'hC3);
    bus_write(3'd1, 16'h00C3);
    #(BIT_NS * 2);
    cts_in = 1'b0;
    #(BIT_NS * 10);
    check(tx_frames == 3, "R4 in-flight frame completes", tx_frames, 3);
    frames_before = tx_frames;
    bus_write(3'd1, 16'h0077);
    #(BIT_NS * 12);
    check(tx_frames == frames_before && txd == 1'b1, "R4 no start while blocked", tx_frames, frames_before);
    bus_read(3'd2, v);
    check(v == 16'd0, "R5 idle but blocked", v, 0);
    cts_in = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(3'd2, v);
    check(v == 16'd1, "R5 ready again", v, 1);
    txq.push_back(8'h0F);
    bus_write(3'd1, 16'h000F);
    #(BIT_NS * 11);
    check(txq.size() == 0, "R2 frame after resume", txq.size(), 0);

    // R6 R7 receive path
    send_rx(8'h81, 1'b1);
    send_rx(8'h42, 1'b1);
    send_rx(8'hE7, 1'b1);
    bus_read(3'd4, v);
    check(v == 16'd3, "R7 count three", v, 3);
    bus_read(3'd3, v);
    check(v == 16'd1, "R7 data available", v, 1);
    read_rx_expect();
    bus_read(3'd4, v);
    check(v == 16'd2, "R7 count after pop", v, 2);
    read_rx_expect();
    read_rx_expect();
    bus_read(3'd5, v);
    check(v == 16'd0, "R10 empty read returns zero", v, 0);
    bus_read(3'd4, v);
    check(v == 16'd0, "R10 count stays zero", v, 0);

    // R8 threshold
    for (int i = 0; i < 485; i++) send_rx(8'(i) ^ 8'h5A, 1'b1);
    check(cts_out == 1'b1, "R8 high at 485", cts_out, 1);
    send_rx(8'h99, 1'b1);
    check(cts_out == 1'b0, "R8 low at 486", cts_out, 0);
    read_rx_expect();
    repeat (2) @(negedge clk);
    check(cts_out == 1'b1, "R8 high after pop", cts_out, 1);

    // R9 fill to full and overrun
    for (int i = 0; i < 27; i++) send_rx(8'(i) ^ 8'hC6, 1'b1);
    bus_read(3'd4, v);
    check(v == 16'd512, "R9 queue full", v, 512);
    send_rx(8'hEE, 1'b0);
    bus_read(3'd4, v);
    check(v == 16'd512, "R9 dropped byte", v, 512);
    bus_read(3'd3, v);
    check(v == 16'd3, "R9 overrun set", v, 3);
    bus_write(3'd3, 16'h0002);
    bus_read(3'd3, v);
    check(v == 16'd1, "R9 overrun cleared", v, 1);
    while (rxq.size() > 0) read_rx_expect();
    bus_read(3'd3, v);
    check(v == 16'd0, "R7 drained", v, 0);
    repeat (2) @(negedge clk);
    check(cts_out == 1'b1, "R8 high when empty", cts_out, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule